// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This peripheral holds one 8-bit up-counter that advances on single-cycle enables from a prescaler. A 3-bit select field chooses the division ratio. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set. One mode bit decides what the wrap does. In interval mode it raises a level interrupt, which stays high until software clears the flag. In watchdog mode it emits a fixed-length active-low overflow pulse and also sets a second flag in the reset status register. The chip reset generator and the interrupt controller are outside the block; they only see the two output pins.

Software reaches the three registers over a small request/acknowledge bus. The requester raises `bus_req` and holds it, together with the address, size, direction and write data, until `bus_ack` is seen. The block paces every access to three cycles and offers no other back-pressure. The requester drops `bus_req` for at least one cycle after the acknowledge, unless it wants to start the next access straight away. Writes are accepted only as 16-bit words whose upper byte is a key. Reads are accepted only as bytes. For this reason the write address map and the read address map differ.

Top module: `wdg_interval_timer`

## Requirements
- R1: After reset, the status/control byte reads 0x18, the counter reads 0x00 and the reset status byte reads 0x1F. `wdog_ovf_n` is high and `tmr_irq` is low.
- R2: The block asserts `bus_ack` for exactly one cycle, once `bus_req` has been held high across two rising edges. The access takes effect at the third rising edge.
- R3: A write takes effect only when `bus_size` is 1 (word) and the word offset is 0 or 2. Writes with `bus_size` 0 (byte) or 2 (longword), and writes at other offsets, change nothing.
- R4: For a word write at offset 0, the upper data byte is a key. Key 0xA5 loads the status/control byte: bit 6 is the mode (1 = watchdog, 0 = interval), bit 5 is enable, bits 2:0 are the clock select, and bits 4:3 always read 1. Key 0x5A loads the counter. For a word write at offset 2, key 0xA5 loads bits 6:5 of the reset status byte, and its bits 4:0 always read 1. Any other key is ignored.
- R5: Only byte reads return data: offset 0 gives status/control, offset 1 gives the counter and offset 3 gives reset status. Word and longword reads, and a byte read at offset 2, return 0x00.
- R6: Select codes 0 to 7 divide the clock by 2, 64, 128, 256, 512, 1024, 4096 and 8192. The prescaler is held clear while the timer is disabled. Starting from the write that enables the timer, the counter therefore advances every N cycles, the first time N cycles after that write.
- R7: Writing status/control with enable 0 clears the counter to 0x00, and the counter then holds its value until it is written again.
- R8: A wrap from 0xFF to 0x00 sets status/control bit 7 in either mode. The counter keeps counting after the wrap.
- R9: `tmr_irq` is high while the overflow flag is set and the mode is interval. It is low in watchdog mode.
- R10: In watchdog mode, a wrap drives `wdog_ovf_n` low for exactly 128 cycles, starting at the edge of the wrap. The same wrap sets reset status bit 7.
- R11: A status bit 7 is cleared by writing 0 only if the most recent read of that register returned it as 1, with no write to that register since that read. Writing 1, or writing 0 without that read, leaves the bit set. If a wrap and a clear fall in the same cycle, the wrap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_addr | input | 2 | Byte offset within the block |
| bus_wdata | input | 16 | Write word: key in [15:8], value in [7:0] |
| bus_ack | output | 1 | Access completes this cycle |
| bus_rdata | output | 8 | Read byte, valid while `bus_ack` is high |
| wdog_ovf_n | output | 1 | Active-low watchdog overflow pulse |
| tmr_irq | output | 1 | Interval-timer interrupt level |

## Verification
A wrong prescaler tap or a wrong counter value shows as a shifted overflow time. That shift appears at `tmr_irq` or `wdog_ovf_n`, at the latest after 256 times the division ratio. The bench sweeps every select code from a preloaded count, so each error is seen within a few thousand cycles. Faults in the access rules, such as a wrong key compare, a wrong size check or lost flag arming, show on the very next byte read of the affected register. A pulse counter that is off by one shows as a low time other than 128 cycles on `wdog_ovf_n`.

// File: rtl/wit_pkg.sv
package wit_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } bus_size_e;

  // log2 of the division ratio chosen by each select code
  function automatic int unsigned div_log2(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 9;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/wit_bus_port.sv
module wit_bus_port
  import wit_pkg::*;
#(
  parameter int unsigned ACCESS_CYC = 3,
  parameter logic [7:0]  KEY_CTL    = 8'hA5,
  parameter logic [7:0]  KEY_CNT    = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       addr_i,
  input  logic [15:0]      wdata_i,
  output logic             ack_o,
  output logic [REG_W-1:0] rdata_o,
  input  logic [REG_W-1:0] ctl_byte_i,
  input  logic [REG_W-1:0] cnt_i,
  input  logic [REG_W-1:0] rst_byte_i,
  output logic             wr_ctl_o,
  output logic             wr_cnt_o,
  output logic             wr_rst_o,
  output logic [REG_W-1:0] wbyte_o,
  output logic             rd_ctl_o,
  output logic             rd_rst_o
);
  localparam int unsigned PH_W = (ACCESS_CYC > 2) ? $clog2(ACCESS_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(ACCESS_CYC - 1);

  logic [PH_W-1:0] phase;
  logic            word_wr, byte_rd;
  logic [7:0]      key;

  assign ack_o = req_i && (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (ack_o)  phase <= '0;
    else if (req_i)  phase <= phase + 1'b1;
    else             phase <= '0;
  end

  assign key     = wdata_i[15:8];
  assign word_wr = ack_o && we_i && (size_i == SZ_WORD);
  assign byte_rd = ack_o && !we_i && (size_i == SZ_BYTE);

  assign wr_ctl_o = word_wr && (addr_i == 2'd0) && (key == KEY_CTL);
  assign wr_cnt_o = word_wr && (addr_i == 2'd0) && (key == KEY_CNT);
  assign wr_rst_o = word_wr && (addr_i == 2'd2) && (key == KEY_CTL);
  assign wbyte_o  = wdata_i[7:0];
  assign rd_ctl_o = byte_rd && (addr_i == 2'd0);
  assign rd_rst_o = byte_rd && (addr_i == 2'd3);

  always_comb begin
    rdata_o = '0;
    if (byte_rd) begin
      case (addr_i)
        2'd0:    rdata_o = ctl_byte_i;
        2'd1:    rdata_o = cnt_i;
        2'd3:    rdata_o = rst_byte_i;
        default: rdata_o = '0;
      endcase
    end
  end

  // R2: acknowledge only after the request was held, and never twice in a row
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(req_i) && $past(req_i, 2)));
  a_r2_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R3: non-word writes reach no register
  a_r3_no_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && we_i && (size_i != SZ_WORD)) |-> !(wr_ctl_o || wr_cnt_o || wr_rst_o));
  // R5: wide reads carry no data
  a_r5_wide_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !we_i && (size_i != SZ_BYTE)) |-> (rdata_o == '0));
endmodule

// File: rtl/wit_prescaler.sv
module wit_prescaler
  import wit_pkg::*;
#(
  parameter int unsigned PSC_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i < int'(div_log2(sel_i))) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     psc <= '0;
    else if (!en_i) psc <= '0;
    else            psc <= psc + 1'b1;
  end

  assign tick_o = en_i && ((psc & mask) == mask);

  // R6: a disabled prescaler stays at zero
  a_r6_psc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_i)) |-> (psc == '0));
endmodule

// File: rtl/wit_core.sv
module wit_core
  import wit_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rst_i,
  input  logic [REG_W-1:0] wbyte_i,
  input  logic             rd_ctl_i,
  input  logic             rd_rst_i,
  input  logic             tick_i,
  output logic             en_o,
  output logic [2:0]       sel_o,
  output logic [REG_W-1:0] ctl_byte_o,
  output logic [REG_W-1:0] cnt_o,
  output logic [REG_W-1:0] rst_byte_o,
  output logic             irq_o,
  output logic             wdog_ovf_n_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);
  localparam logic [REG_W-1:0] CNT_MAX = '1;

  logic             ctl_flag, mode_wd, en, ctl_arm;
  logic [2:0]       sel;
  logic [REG_W-1:0] cnt;
  logic             rst_flag, rst_b6, rst_b5, rst_arm;
  logic [PW-1:0]    pcnt;
  logic             adv, ovf_evt, clr_cnt;

  assign clr_cnt = wr_ctl_i && !wbyte_i[5];
  assign adv     = en && tick_i && !wr_ctl_i && !wr_cnt_i;
  assign ovf_evt = adv && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr_cnt)  cnt <= '0;
    else if (wr_cnt_i) cnt <= wbyte_i;
    else if (adv)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_wd <= 1'b0;
      en      <= 1'b0;
      sel     <= 3'd0;
    end else if (wr_ctl_i) begin
      mode_wd <= wbyte_i[6];
      en      <= wbyte_i[5];
      sel     <= wbyte_i[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_flag <= 1'b0;
      ctl_arm  <= 1'b0;
    end else begin
      if (ovf_evt)                             ctl_flag <= 1'b1;
      else if (wr_ctl_i && ctl_arm && !wbyte_i[7]) ctl_flag <= 1'b0;
      if (wr_ctl_i)                            ctl_arm <= 1'b0;
      else if (rd_ctl_i && ctl_flag)           ctl_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_flag <= 1'b0;
      rst_b6   <= 1'b0;
      rst_b5   <= 1'b0;
      rst_arm  <= 1'b0;
    end else begin
      if (ovf_evt && mode_wd)                      rst_flag <= 1'b1;
      else if (wr_rst_i && rst_arm && !wbyte_i[7]) rst_flag <= 1'b0;
      if (wr_rst_i) begin
        rst_b6  <= wbyte_i[6];
        rst_b5  <= wbyte_i[5];
        rst_arm <= 1'b0;
      end else if (rd_rst_i && rst_flag) begin
        rst_arm <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcnt <= '0;
    else if (ovf_evt && mode_wd) pcnt <= PW'(PULSE_CYC);
    else if (pcnt != '0)         pcnt <= pcnt - 1'b1;
  end

  assign en_o         = en;
  assign sel_o        = sel;
  assign cnt_o        = cnt;
  assign ctl_byte_o   = {ctl_flag, mode_wd, en, 2'b11, sel};
  assign rst_byte_o   = {rst_flag, rst_b6, rst_b5, 5'h1F};
  assign irq_o        = ctl_flag && !mode_wd;
  assign wdog_ovf_n_o = (pcnt == '0);

  // R6/R8: without a write the counter only ever steps by one
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != $past(cnt)) && !$past(wr_ctl_i) && !$past(wr_cnt_i))
      |-> (cnt == $past(cnt) + 1'b1));
  // R7: a disabled counter holds
  a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en) && !$past(wr_cnt_i) && !$past(wr_ctl_i)) |-> $stable(cnt));
  // R10: pulse start coincides with both flags set
  a_r10_pulse_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_ovf_n_o) |-> (ctl_flag && rst_flag));
  // R11: the flag falls only through an armed control write
  a_r11_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_flag) |-> ($past(wr_ctl_i) && $past(ctl_arm)));
endmodule

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer
  import wit_pkg::*;
#(
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned PSC_W      = 13,
  parameter int unsigned PULSE_CYC  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [1:0]  bus_size,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic        bus_ack,
  output logic [7:0]  bus_rdata,
  output logic        wdog_ovf_n,
  output logic        tmr_irq
);
  logic             wr_ctl, wr_cnt, wr_rst, rd_ctl, rd_rst, tick, en;
  logic [2:0]       sel;
  logic [REG_W-1:0] wbyte, ctl_byte, cnt, rst_byte;

  wit_bus_port #(.ACCESS_CYC(ACCESS_CYC)) u_port (
    .clk(clk), .rst_n(rst_n), .req_i(bus_req), .we_i(bus_we),
    .size_i(bus_size), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .ack_o(bus_ack), .rdata_o(bus_rdata),
    .ctl_byte_i(ctl_byte), .cnt_i(cnt), .rst_byte_i(rst_byte),
    .wr_ctl_o(wr_ctl), .wr_cnt_o(wr_cnt), .wr_rst_o(wr_rst),
    .wbyte_o(wbyte), .rd_ctl_o(rd_ctl), .rd_rst_o(rd_rst)
  );

  wit_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sel_i(sel), .tick_o(tick)
  );

  wit_core #(.PULSE_CYC(PULSE_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_ctl_i(wr_ctl), .wr_cnt_i(wr_cnt),
    .wr_rst_i(wr_rst), .wbyte_i(wbyte), .rd_ctl_i(rd_ctl), .rd_rst_i(rd_rst),
    .tick_i(tick), .en_o(en), .sel_o(sel), .ctl_byte_o(ctl_byte),
    .cnt_o(cnt), .rst_byte_o(rst_byte), .irq_o(tmr_irq),
    .wdog_ovf_n_o(wdog_ovf_n)
  );
endmodule

// File: tb/tb_wdg_interval_timer.sv
`timescale 1ns/1ps
module tb_wdg_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic        bus_ack;
  logic [7:0]  bus_rdata;
  logic        wdog_ovf_n;
  logic        tmr_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .wdog_ovf_n(wdog_ovf_n),
    .tmr_irq(tmr_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ratio(input int sel);
    if (sel == 0) return 2;
    else if (sel < 6) return 1 << (sel + 5);
    else return 1 << (sel + 6);
  endfunction

  int last_waits;

  task automatic access(input logic we, input logic [1:0] size,
                        input logic [1:0] addr, input logic [15:0] wd,
                        output logic [7:0] rd);
    int waits = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = size; bus_addr = addr; bus_wdata = wd;
    do begin
      @(negedge clk);
      waits++;
    end while (!bus_ack && waits < 20);
    rd = bus_rdata;
    last_waits = waits;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] wd);
    logic [7:0] d;
    access(1'b1, 2'd1, addr, wd, d);
  endtask

  task automatic rd_byte(input logic [1:0] addr, output logic [7:0] d);
    access(1'b0, 2'd0, addr, 16'h0, d);
  endtask

  initial begin
    wait (cyc > 190000);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk("R1 ovf_n", int'(wdog_ovf_n), 1);
    chk("R1 irq", int'(tmr_irq), 0);
    rd_byte(2'd0, d); chk("R1 ctl", d, 8'h18);
    chk("R2 ack after two edges", last_waits, 2);
    rd_byte(2'd1, d); chk("R1 cnt", d, 8'h00);
    rd_byte(2'd3, d); chk("R1 rst", d, 8'h1F);

    // R5: other read shapes return zero
    access(1'b0, 2'd1, 2'd0, 16'h0, d); chk("R5 word read", d, 0);
    access(1'b0, 2'd2, 2'd0, 16'h0, d); chk("R5 long read", d, 0);
    rd_byte(2'd2, d); chk("R5 offset 2", d, 0);

    // R3/R4: rejected writes
    access(1'b1, 2'd0, 2'd0, 16'hA527, d); rd_byte(2'd0, d); chk("R3 byte write", d, 8'h18);
    access(1'b1, 2'd2, 2'd0, 16'hA527, d); rd_byte(2'd0, d); chk("R3 long write", d, 8'h18);
    wr(2'd1, 16'hA527); rd_byte(2'd0, d); chk("R3 offset 1", d, 8'h18);
    wr(2'd0, 16'h3327); rd_byte(2'd0, d); chk("R4 bad key", d, 8'h18);
    wr(2'd0, 16'h5A40); rd_byte(2'd1, d); chk("R4 counter load", d, 8'h40);
    wr(2'd2, 16'h3360); rd_byte(2'd3, d); chk("R4 rst bad key", d, 8'h1F);
    wr(2'd2, 16'hA560); rd_byte(2'd3, d); chk("R4 rst load", d, 8'h7F);
    wr(2'd2, 16'hA500); rd_byte(2'd3, d); chk("R4 rst reload", d, 8'h1F);

    // R7: disable clears and stops
    wr(2'd0, 16'hA520);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'hA500); rd_byte(2'd1, d); chk("R7 cleared", d, 0);
    repeat (20) @(negedge clk);
    rd_byte(2'd1, d); chk("R7 held", d, 0);

    // R6/R8/R9: every select code, interval mode, preload 0xFC
    for (int s = 0; s < 8; s++) begin
      rd_byte(2'd0, d);
      wr(2'd0, 16'hA500);
      chk("R9 irq after clear", int'(tmr_irq), 0);
      wr(2'd0, 16'h5AFC);
      wr(2'd0, 16'hA520 | 16'(s));
      t0 = cyc;
      while (!tmr_irq && cyc - t0 < 40000) @(negedge clk);
      chk($sformatf("R6 overflow time sel %0d", s), cyc - t0, 4 * ratio(s));
      chk("R9 irq interval", int'(tmr_irq), 1);
    end
    rd_byte(2'd0, d); chk("R8 flag set", d[7], 1);

    // R11: clear rules (flag currently set, last read armed it)
    wr(2'd0, 16'hA580);
    rd_byte(2'd0, d); chk("R11 write 1 keeps", d, 8'h98);
    wr(2'd0, 16'hA500);
    rd_byte(2'd0, d); chk("R11 armed clear", d, 8'h18);
    chk("R9 irq dropped", int'(tmr_irq), 0);

    // R8: full wrap from zero with ratio 2, continues counting
    wr(2'd0, 16'hA520);
    t0 = cyc;
    while (!tmr_irq && cyc - t0 < 2000) @(negedge clk);
    chk("R8 full wrap", cyc - t0, 512);
    t1 = cyc;
    rd_byte(2'd1, d);
    chk("R8 keeps counting", d, ((cyc - t1) - 1) / 2);

    // R11: unarmed zero write leaves flag
    wr(2'd0, 16'hA500);
    rd_byte(2'd0, d); chk("R11 unarmed keeps", d, 8'h98);
    wr(2'd0, 16'hA500);
    rd_byte(2'd0, d); chk("R11 cleared", d, 8'h18);

    // R10: watchdog mode pulse
    wr(2'd0, 16'h5AFC);
    wr(2'd0, 16'hA560);
    t0 = cyc;
    while (wdog_ovf_n && cyc - t0 < 200) @(negedge clk);
    chk("R10 wd overflow time", cyc - t0, 8);
    chk("R9 no irq in wd mode", int'(tmr_irq), 0);
    t1 = cyc;
    while (!wdog_ovf_n && cyc - t1 < 400) @(negedge clk);
    chk("R10 pulse length", cyc - t1, 128);
    rd_byte(2'd3, d); chk("R10 rst flag", d, 8'h9F);
    rd_byte(2'd0, d); chk("R8 flag wd mode", d[7], 1);
    wr(2'd2, 16'hA500);
    rd_byte(2'd3, d); chk("R11 rst clear", d, 8'h1F);
    wr(2'd0, 16'hA500);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule